// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a memory request into a 20-bit physical address. It takes a 16-bit segment base and a 16-bit offset, shifts the segment left by four bit positions and adds the offset. The offset comes from one of several combinations of a base register, an index register and a displacement. The segment comes from a default rule that depends on the access class and the base register in use. For data accesses, an override code can replace that default.

The four 16-bit segment registers are kept inside the block and are loaded through a simple write port. Each request is presented for one cycle with `req_valid`. One cycle later the block returns four things:

- the effective offset
- the physical address
- even-bank and odd-bank enables
- a flag that marks a word access at an odd address

It does not decode instructions, run bus cycles or split misaligned words.

Top module: `seg_addr_gen`

## Requirements
- R1: Reset loads the code segment with FFFFh and the stack, data and extra segments with 0000h. It also clears `out_valid` and every result output. A fetch with instruction pointer 0000h right after reset therefore yields physical address FFFF0h.
- R2: The physical address equals (segment × 16 + offset) modulo 2^20, so a sum past FFFFFh wraps to the bottom of the space.
- R3: Segment write codes are 0 for extra, 1 for code, 2 for stack and 3 for data. A write is visible to requests in later cycles. A request in the same cycle as a write uses the value from before the write.
- R4: Access class 0 (fetch) always uses the code segment with `req_ip` as the offset. Mode, displacement and override are ignored.
- R5: Access class 1 (stack) always uses the stack segment with `req_sp` as the offset. The override is ignored.
- R6: Access class 2 (data) without an override uses the stack segment when the offset includes the base pointer (`req_base_sel`=1 in modes 1, 3, 5 or 6). Otherwise it uses the data segment.
- R7: For class 2 only, `req_ovr_en`=1 selects the segment given by `req_ovr_sel`, using the same codes as R3.
- R8: Access class 3 (string destination) always uses the extra segment with `req_di` as the offset. The override is ignored.
- R9: Offset modes are as follows. The base is BX when `req_base_sel`=0 and BP when it is 1. The index is SI when `req_index_sel`=0 and DI when it is 1. All sums wrap modulo 65536.

  | Mode | Offset |
  |------|--------|
  | 0 | displacement |
  | 1 | base |
  | 2 | index |
  | 3 | base + displacement |
  | 4 | index + displacement |
  | 5 | base + index |
  | 6 | base + index + displacement |
  | 7 | same as mode 0 |
- R10: When `req_disp_wide`=0, only `req_disp[7:0]` is used, sign-extended to 16 bits. Bits 15:8 have no effect.
- R11: A byte access (`req_word`=0) asserts only `out_even_en` when address bit 0 is 0, and only `out_odd_en` when it is 1. `out_misaligned` stays 0.
- R12: A word access at an even address asserts both enables. A word access at an odd address sets `out_misaligned` and asserts only `out_odd_en`.
- R13: Results appear one cycle after the request, and `out_valid` equals the previous cycle's `req_valid`. Without a request, the result outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment to write (0 extra, 1 code, 2 stack, 3 data) |
| seg_wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Request strobe |
| req_class | input | 2 | Access class (0 fetch, 1 stack, 2 data, 3 string destination) |
| req_mode | input | 3 | Offset mode for data accesses |
| req_base_sel | input | 1 | Base register choice (0 BX, 1 BP) |
| req_index_sel | input | 1 | Index register choice (0 SI, 1 DI) |
| req_bx | input | 16 | BX value |
| req_bp | input | 16 | BP value |
| req_si | input | 16 | SI value |
| req_di | input | 16 | DI value |
| req_sp | input | 16 | Stack pointer value |
| req_ip | input | 16 | Instruction pointer value |
| req_disp | input | 16 | Displacement |
| req_disp_wide | input | 1 | 1: 16-bit displacement, 0: sign-extended low byte |
| req_ovr_en | input | 1 | Segment override present |
| req_ovr_sel | input | 2 | Override segment code |
| req_word | input | 1 | 1: word access, 0: byte access |
| out_valid | output | 1 | Result valid |
| out_offset | output | 16 | Effective offset |
| out_paddr | output | 20 | Physical address |
| out_even_en | output | 1 | Even bank enable |
| out_odd_en | output | 1 | Odd bank enable |
| out_misaligned | output | 1 | Word access at odd address |

## Verification
The bench builds the block with its default parameters:

- 16-bit segments and offsets
- a 4-bit segment shift
- an 8-bit narrow displacement

With full-range random segment values, the bench reaches segment values near FFFFh, where the physical sum passes FFFFFh and must wrap. With full-range random register and displacement values, the three-term offsets overflow 16 bits. Random narrow displacements with the sign bit set exercise the sign extension. Segment writes issued in the same cycle as requests test the rule that a request sees the old segment value.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    CLS_FETCH  = 2'd0,
    CLS_STACK  = 2'd1,
    CLS_DATA   = 2'd2,
    CLS_STRDST = 2'd3
  } acc_class_e;

  typedef enum logic [2:0] {
    MD_DIRECT          = 3'd0,
    MD_BASE            = 3'd1,
    MD_INDEX           = 3'd2,
    MD_BASE_DISP       = 3'd3,
    MD_INDEX_DISP      = 3'd4,
    MD_BASE_INDEX      = 3'd5,
    MD_BASE_INDEX_DISP = 3'd6,
    MD_RSVD            = 3'd7
  } ofs_mode_e;

  function automatic logic mode_has_base(ofs_mode_e m);
    return (m == MD_BASE) || (m == MD_BASE_DISP) ||
           (m == MD_BASE_INDEX) || (m == MD_BASE_INDEX_DISP);
  endfunction

  function automatic logic mode_has_index(ofs_mode_e m);
    return (m == MD_INDEX) || (m == MD_INDEX_DISP) ||
           (m == MD_BASE_INDEX) || (m == MD_BASE_INDEX_DISP);
  endfunction

  function automatic logic mode_has_disp(ofs_mode_e m);
    return (m == MD_DIRECT) || (m == MD_RSVD) || (m == MD_BASE_DISP) ||
           (m == MD_INDEX_DISP) || (m == MD_BASE_INDEX_DISP);
  endfunction

  // Offset built on the base pointer defaults to the stack segment.
  function automatic logic mode_defaults_to_stack(ofs_mode_e m, logic base_is_bp);
    return base_is_bp && mode_has_base(m);
  endfunction

endpackage

// File: rtl/seg_bank.sv
module seg_bank
  import seg_addr_pkg::*;
#(
  parameter int SEG_W    = 16,
  parameter int RESET_CS = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  seg_id_e          wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  seg_id_e          rd_sel,
  output logic [SEG_W-1:0] rd_data
);
  localparam int NUM_SEG = 4;

  logic [SEG_W-1:0] seg_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam logic [SEG_W-1:0] INIT_VAL =
      (g == int'(SEG_CS)) ? SEG_W'(RESET_CS) : '0;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seg_q[g] <= INIT_VAL;
      end else if (wr_en && (int'(wr_sel) == g)) begin
        seg_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = seg_q[rd_sel];

endmodule

// File: rtl/seg_offset_unit.sv
module seg_offset_unit
  import seg_addr_pkg::*;
#(
  parameter int OFF_W    = 16,
  parameter int NARROW_W = 8
) (
  input  ofs_mode_e        mode,
  input  logic             base_sel,
  input  logic             index_sel,
  input  logic [OFF_W-1:0] bx,
  input  logic [OFF_W-1:0] bp,
  input  logic [OFF_W-1:0] si,
  input  logic [OFF_W-1:0] di,
  input  logic [OFF_W-1:0] disp,
  input  logic             disp_wide,
  output logic [OFF_W-1:0] offset
);
  localparam int EXT_W = OFF_W - NARROW_W;

  function automatic logic [OFF_W-1:0] extend_disp(logic [OFF_W-1:0] d, logic wide);
    if (wide) return d;
    return {{EXT_W{d[NARROW_W-1]}}, d[NARROW_W-1:0]};
  endfunction

  function automatic logic [OFF_W-1:0] sum3(logic [OFF_W-1:0] a,
                                            logic [OFF_W-1:0] b,
                                            logic [OFF_W-1:0] c);
    return a + b + c;
  endfunction

  logic [OFF_W-1:0] base_val, index_val, disp_val;
  logic [OFF_W-1:0] base_term, index_term, disp_term;

  assign base_val   = base_sel  ? bp : bx;
  assign index_val  = index_sel ? di : si;
  assign disp_val   = extend_disp(disp, disp_wide);

  assign base_term  = mode_has_base(mode)  ? base_val  : '0;
  assign index_term = mode_has_index(mode) ? index_val : '0;
  assign disp_term  = mode_has_disp(mode)  ? disp_val  : '0;

  assign offset = sum3(base_term, index_term, disp_term);

endmodule

// File: rtl/seg_route.sv
module seg_route
  import seg_addr_pkg::*;
(
  input  acc_class_e cls,
  input  ofs_mode_e  mode,
  input  logic       base_sel,
  input  logic       ovr_en,
  input  seg_id_e    ovr_sel,
  output seg_id_e    seg_sel,
  output logic       ovr_taken
);
  assign ovr_taken = ovr_en && (cls == CLS_DATA);

  always_comb begin
    unique case (cls)
      CLS_FETCH:  seg_sel = SEG_CS;
      CLS_STACK:  seg_sel = SEG_SS;
      CLS_STRDST: seg_sel = SEG_ES;
      default: begin
        if (ovr_taken)                               seg_sel = ovr_sel;
        else if (mode_defaults_to_stack(mode, base_sel)) seg_sel = SEG_SS;
        else                                          seg_sel = SEG_DS;
      end
    endcase
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int NARROW_W  = 8,
  parameter int RESET_CS  = 16'hFFFF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       seg_wr_en,
  input  logic [1:0]                 seg_wr_sel,
  input  logic [SEG_W-1:0]           seg_wr_data,
  input  logic                       req_valid,
  input  logic [1:0]                 req_class,
  input  logic [2:0]                 req_mode,
  input  logic                       req_base_sel,
  input  logic                       req_index_sel,
  input  logic [OFF_W-1:0]           req_bx,
  input  logic [OFF_W-1:0]           req_bp,
  input  logic [OFF_W-1:0]           req_si,
  input  logic [OFF_W-1:0]           req_di,
  input  logic [OFF_W-1:0]           req_sp,
  input  logic [OFF_W-1:0]           req_ip,
  input  logic [OFF_W-1:0]           req_disp,
  input  logic                       req_disp_wide,
  input  logic                       req_ovr_en,
  input  logic [1:0]                 req_ovr_sel,
  input  logic                       req_word,
  output logic                       out_valid,
  output logic [OFF_W-1:0]           out_offset,
  output logic [SEG_W+SEG_SHIFT-1:0] out_paddr,
  output logic                       out_even_en,
  output logic                       out_odd_en,
  output logic                       out_misaligned
);
  localparam int PADDR_W = SEG_W + SEG_SHIFT;

  function automatic logic [PADDR_W-1:0] phys_sum(logic [SEG_W-1:0] s,
                                                  logic [OFF_W-1:0] o);
    return {s, {SEG_SHIFT{1'b0}}} + PADDR_W'(o);
  endfunction

  acc_class_e cls;
  ofs_mode_e  mode;
  assign cls  = acc_class_e'(req_class);
  assign mode = ofs_mode_e'(req_mode);

  // Named internal events
  seg_id_e          sel_seg;
  logic             ovr_taken;
  logic [SEG_W-1:0] seg_val;
  logic [OFF_W-1:0] data_offset;
  logic [OFF_W-1:0] eff_offset;
  logic [PADDR_W-1:0] eff_paddr;
  logic             odd_addr;
  logic             word_split;
  logic             even_en_d, odd_en_d;

  seg_bank #(.SEG_W(SEG_W), .RESET_CS(RESET_CS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (seg_wr_en),
    .wr_sel  (seg_id_e'(seg_wr_sel)),
    .wr_data (seg_wr_data),
    .rd_sel  (sel_seg),
    .rd_data (seg_val)
  );

  seg_offset_unit #(.OFF_W(OFF_W), .NARROW_W(NARROW_W)) u_ofs (
    .mode      (mode),
    .base_sel  (req_base_sel),
    .index_sel (req_index_sel),
    .bx        (req_bx),
    .bp        (req_bp),
    .si        (req_si),
    .di        (req_di),
    .disp      (req_disp),
    .disp_wide (req_disp_wide),
    .offset    (data_offset)
  );

  seg_route u_route (
    .cls       (cls),
    .mode      (mode),
    .base_sel  (req_base_sel),
    .ovr_en    (req_ovr_en),
    .ovr_sel   (seg_id_e'(req_ovr_sel)),
    .seg_sel   (sel_seg),
    .ovr_taken (ovr_taken)
  );

  always_comb begin
    unique case (cls)
      CLS_FETCH:  eff_offset = req_ip;
      CLS_STACK:  eff_offset = req_sp;
      CLS_STRDST: eff_offset = req_di;
      default:    eff_offset = data_offset;
    endcase
  end

  assign eff_paddr  = phys_sum(seg_val, eff_offset);
  assign odd_addr   = eff_paddr[0];
  assign word_split = req_word && odd_addr;
  assign even_en_d  = !odd_addr;
  assign odd_en_d   = odd_addr || req_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_offset     <= '0;
      out_paddr      <= '0;
      out_even_en    <= 1'b0;
      out_odd_en     <= 1'b0;
      out_misaligned <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_offset     <= eff_offset;
        out_paddr      <= eff_paddr;
        out_even_en    <= even_en_d;
        out_odd_en     <= odd_en_d;
        out_misaligned <= word_split;
      end
    end
  end

endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
  parameter int OFF_W   = 16,
  parameter int PADDR_W = 20,
  parameter int SHIFT   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         req_class,
  input logic               req_word,
  input logic [OFF_W-1:0]   req_ip,
  input logic [OFF_W-1:0]   req_sp,
  input logic [OFF_W-1:0]   req_di,
  input logic               ovr_taken,
  input logic               out_valid,
  input logic [OFF_W-1:0]   out_offset,
  input logic [PADDR_W-1:0] out_paddr,
  input logic               out_even_en,
  input logic               out_odd_en,
  input logic               out_misaligned
);
  assert_valid_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(req_valid)));

  assert_hold_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(out_paddr) && $stable(out_offset)));

  assert_fetch_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 2'd0) |=> (out_offset == $past(req_ip)));

  assert_stack_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 2'd1) |=> (out_offset == $past(req_sp)));

  assert_strdst_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 2'd3) |=> (out_offset == $past(req_di)));

  assert_override_data_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_taken |-> (req_class == 2'd2));

  assert_low_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_paddr[SHIFT-1:0] == out_offset[SHIFT-1:0]));

  assert_byte_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_word) |=>
      ($onehot({out_even_en, out_odd_en}) && (out_even_en == !out_paddr[0]) && !out_misaligned));

  assert_word_split_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_word) |=> (out_misaligned == out_paddr[0]) && out_odd_en);

  assert_misaligned_lane_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_misaligned |-> (out_odd_en && !out_even_en && out_paddr[0]));

endmodule

bind seg_addr_gen seg_addr_chk #(
  .OFF_W   (OFF_W),
  .PADDR_W (SEG_W + SEG_SHIFT),
  .SHIFT   (SEG_SHIFT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_class      (req_class),
  .req_word       (req_word),
  .req_ip         (req_ip),
  .req_sp         (req_sp),
  .req_di         (req_di),
  .ovr_taken      (ovr_taken),
  .out_valid      (out_valid),
  .out_offset     (out_offset),
  .out_paddr      (out_paddr),
  .out_even_en    (out_even_en),
  .out_odd_en     (out_odd_en),
  .out_misaligned (out_misaligned)
);

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 4000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        seg_wr_en;
  logic [1:0]  seg_wr_sel;
  logic [15:0] seg_wr_data;
  logic        req_valid;
  logic [1:0]  req_class;
  logic [2:0]  req_mode;
  logic        req_base_sel, req_index_sel;
  logic [15:0] req_bx, req_bp, req_si, req_di, req_sp, req_ip, req_disp;
  logic        req_disp_wide, req_ovr_en;
  logic [1:0]  req_ovr_sel;
  logic        req_word;
  logic        out_valid;
  logic [15:0] out_offset;
  logic [19:0] out_paddr;
  logic        out_even_en, out_odd_en, out_misaligned;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen u0 (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
    .req_valid(req_valid), .req_class(req_class), .req_mode(req_mode),
    .req_base_sel(req_base_sel), .req_index_sel(req_index_sel),
    .req_bx(req_bx), .req_bp(req_bp), .req_si(req_si), .req_di(req_di),
    .req_sp(req_sp), .req_ip(req_ip), .req_disp(req_disp),
    .req_disp_wide(req_disp_wide), .req_ovr_en(req_ovr_en),
    .req_ovr_sel(req_ovr_sel), .req_word(req_word),
    .out_valid(out_valid), .out_offset(out_offset), .out_paddr(out_paddr),
    .out_even_en(out_even_en), .out_odd_en(out_odd_en),
    .out_misaligned(out_misaligned)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit checking_on = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int    m_seg [4];
  int    e_valid, e_off, e_pa, e_even, e_odd, e_mis;
  string t_off, t_pa, t_lane;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_seg[0] = 0; m_seg[1] = 'hFFFF; m_seg[2] = 0; m_seg[3] = 0;
      e_valid = 0; e_off = 0; e_pa = 0; e_even = 0; e_odd = 0; e_mis = 0;
      t_off = "R1"; t_pa = "R1"; t_lane = "R1";
    end else begin
      e_valid = int'(req_valid);
      if (req_valid) begin
        int b, x, d, sum, s;
        b = req_base_sel ? int'(req_bp) : int'(req_bx);
        x = req_index_sel ? int'(req_di) : int'(req_si);
        if (req_disp_wide) d = int'(req_disp);
        else d = req_disp[7] ? int'(req_disp[7:0]) - 256 : int'(req_disp[7:0]);
        case (req_mode)
          3'd1: sum = b;
          3'd2: sum = x;
          3'd3: sum = b + d;
          3'd4: sum = x + d;
          3'd5: sum = b + x;
          3'd6: sum = b + x + d;
          default: sum = d;
        endcase
        case (req_class)
          2'd0: begin e_off = int'(req_ip); s = m_seg[1]; t_off = "R4"; t_pa = "R4"; end
          2'd1: begin e_off = int'(req_sp); s = m_seg[2]; t_off = "R5"; t_pa = "R5"; end
          2'd3: begin e_off = int'(req_di); s = m_seg[0]; t_off = "R8"; t_pa = "R8"; end
          default: begin
            e_off = ((sum % 65536) + 65536) % 65536;
            t_off = req_disp_wide ? "R9" : "R10";
            if (req_ovr_en) begin s = m_seg[req_ovr_sel]; t_pa = "R7"; end
            else if (req_base_sel && (req_mode inside {3'd1, 3'd3, 3'd5, 3'd6})) begin
              s = m_seg[2]; t_pa = "R6";
            end else begin s = m_seg[3]; t_pa = "R6"; end
          end
        endcase
        if (seg_wr_en) t_pa = "R3";
        else if (s * 16 + e_off > 'hFFFFF) t_pa = "R2";
        e_pa = (s * 16 + e_off) % 1048576;
        if (!req_word) begin
          e_even = (e_pa % 2 == 0); e_odd = (e_pa % 2 == 1); e_mis = 0; t_lane = "R11";
        end else begin
          e_mis = e_pa % 2; e_even = (e_mis == 0); e_odd = 1; t_lane = "R12";
        end
      end else begin
        t_off = "R13"; t_pa = "R13"; t_lane = "R13";
      end
      if (seg_wr_en) m_seg[seg_wr_sel] = int'(seg_wr_data);
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (checking_on) begin
      chk(int'(out_valid) == e_valid, "R13", out_valid, e_valid);
      chk(int'(out_offset) == e_off, t_off, out_offset, e_off);
      chk(int'(out_paddr) == e_pa, t_pa, out_paddr, e_pa);
      chk(int'(out_even_en) == e_even && int'(out_odd_en) == e_odd,
          t_lane, {out_even_en, out_odd_en}, e_even * 2 + e_odd);
      chk(int'(out_misaligned) == e_mis, t_lane, out_misaligned, e_mis);
    end
  end

  task automatic idle_inputs();
    seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0;
    req_valid = 0; req_class = 0; req_mode = 0; req_base_sel = 0; req_index_sel = 0;
    req_bx = 0; req_bp = 0; req_si = 0; req_di = 0; req_sp = 0; req_ip = 0;
    req_disp = 0; req_disp_wide = 1; req_ovr_en = 0; req_ovr_sel = 0; req_word = 0;
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(out_paddr == 20'h0, "R1", out_paddr, 0);
    checking_on = 1;
    // R1: fetch at IP 0 after reset
    req_valid = 1; req_class = 2'd0; req_ip = 16'h0000; req_word = 1;
    @(negedge clk);
    chk(out_paddr == 20'hFFFF0, "R1", out_paddr, 20'hFFFF0);
    // R3: write DS while a data request uses it in the same cycle
    req_class = 2'd2; req_mode = 3'd0; req_disp = 16'h0010; req_ovr_en = 0; req_word = 0;
    seg_wr_en = 1; seg_wr_sel = 2'd3; seg_wr_data = 16'h1234;
    @(negedge clk);
    chk(out_paddr == 20'h00010, "R3", out_paddr, 20'h00010);
    seg_wr_en = 0;
    @(negedge clk);
    chk(out_paddr == 20'h12350, "R3", out_paddr, 20'h12350);
    // R10: narrow displacement 0x80 with junk upper byte -> -128
    req_mode = 3'd3; req_bx = 16'h0100; req_base_sel = 0; req_disp = 16'hA580; req_disp_wide = 0;
    @(negedge clk);
    chk(out_offset == 16'h0080, "R10", out_offset, 16'h0080);
    // R2: wrap past the top of the 1 MB space
    seg_wr_en = 1; seg_wr_sel = 2'd3; seg_wr_data = 16'hFFFF; req_valid = 0;
    @(negedge clk);
    seg_wr_en = 0; req_valid = 1; req_mode = 3'd0; req_disp = 16'h0025; req_disp_wide = 1;
    @(negedge clk);
    chk(out_paddr == 20'h00015, "R2", out_paddr, 20'h00015);
    // R13: no request, outputs hold
    req_valid = 0; req_disp = 16'h4444;
    @(negedge clk);
    chk(out_paddr == 20'h00015 && !out_valid, "R13", out_paddr, 20'h00015);
    // Random traffic against the model
    for (int i = 0; i < N_RANDOM; i++) begin
      seg_wr_en     = ($urandom_range(9) == 0);
      seg_wr_sel    = 2'($urandom);
      seg_wr_data   = 16'($urandom);
      req_valid     = ($urandom_range(3) != 0);
      req_class     = 2'($urandom);
      req_mode      = 3'($urandom);
      req_base_sel  = 1'($urandom);
      req_index_sel = 1'($urandom);
      req_bx = 16'($urandom); req_bp = 16'($urandom);
      req_si = 16'($urandom); req_di = 16'($urandom);
      req_sp = 16'($urandom); req_ip = 16'($urandom);
      req_disp      = 16'($urandom);
      req_disp_wide = 1'($urandom);
      req_ovr_en    = 1'($urandom);
      req_ovr_sel   = 2'($urandom);
      req_word      = 1'($urandom);
      @(negedge clk);
    end
    idle_inputs();
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule